// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one compare channel of a general-purpose timer. Each cycle it takes the live counter value and a count-direction flag from the timer core. It compares the counter with an active compare value and drives a registered reference level, OCREF, according to a 3-bit mode. The mode set covers hold, set on match, clear on match, toggle on match, forced low, forced high and two direction-aware PWM shapes.

The compare value is loaded through a simple write port. The preload bit in the control byte decides when a written value takes effect. With preload clear, the active value changes on the next clock edge. With preload set, the write lands in a shadow register, and an update-event strobe from the timer core copies the shadow into the active register. The block also gives a one-cycle match pulse whenever the counter equals the active compare value, which can serve as a flag or interrupt source.

Top module: `oc_channel`

## Requirements
- R1: After reset, the control byte reads 0x00, the active compare value is 0, OCREF is low and the match pulse is low.
- R2: Control byte fields: bits 6:4 are the mode, bit 3 is preload enable, and bits 7, 2, 1:0 are stored and read back. Bits 7, 2 and 1:0 do not change OCREF.
- R3: In mode 0, OCREF holds its level even when the counter equals the compare value.
- R4: Mode 1 sets OCREF high on a cycle where the counter equals the compare value. Mode 2 sets OCREF low on such a cycle. On cycles with no match, both modes hold the level.
- R5: In mode 3, OCREF inverts on every cycle where the counter equals the compare value, and holds otherwise.
- R6: Mode 4 drives OCREF low and mode 5 drives OCREF high, whatever the counter value.
- R7: Mode 6, with the direction flag low (counting up): OCREF is high when counter < compare and low otherwise. Mode 6, with the flag high (counting down): OCREF is high when counter <= compare and low otherwise.
- R8: Mode 7 gives the complement of the mode 6 level for the same counter, compare value and direction.
- R9: With preload clear, a compare write appears as the active compare value after the next clock edge.
- R10: With preload set, a compare write leaves the active value unchanged until a cycle that has the update strobe. That update copies the written value into the active register.
- R11: With preload set, if the update strobe and a compare write fall in the same cycle, the active register takes the newly written value.
- R12: The match output is high for exactly the cycle after each cycle in which the counter equals the active compare value, in every mode.
- R13: OCREF is registered. A control write changes the mode used from the following cycle, so the cycle of the write is still evaluated with the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Live counter value from the timer core |
| cnt_down_i | input | 1 | 1 when the counter is counting down |
| upd_i | input | 1 | Update-event strobe, one cycle |
| ctrl_we_i | input | 1 | Write strobe for the control byte |
| ctrl_wdata_i | input | 8 | Control byte write data |
| cmp_we_i | input | 1 | Write strobe for the compare value |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| ctrl_o | output | 8 | Current control byte |
| cmp_active_o | output | CNT_W | Active compare value |
| ocref_o | output | 1 | Reference output level |
| match_o | output | 1 | One-cycle pulse, counter equalled compare on the previous cycle |

## Verification
The assertions assume that the counter, direction flag, strobes and write data are stable around the rising edge. They also assume the update strobe is a plain per-cycle qualifier, so a strobe held high for several cycles counts as several updates. The bench drives every input on the falling edge and samples one falling edge later, so each input value is seen by exactly one rising edge. Strobes are raised for a single cycle only, except where a held strobe is itself under test.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_HOLD      = 3'd0,
    OC_SET_EQ    = 3'd1,
    OC_CLR_EQ    = 3'd2,
    OC_TOG_EQ    = 3'd3,
    OC_FORCE_LO  = 3'd4,
    OC_FORCE_HI  = 3'd5,
    OC_PWM_A     = 3'd6,
    OC_PWM_B     = 3'd7
  } oc_mode_e;

  // layout decoded by software: do not reorder
  typedef struct packed {
    logic     clr_en;
    oc_mode_e mode;
    logic     pre_en;
    logic     fast_en;
    logic [1:0] dir_sel;
  } oc_ctrl_t;
endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_en_i,
  input  logic             upd_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i) shadow_q <= wdata_i;
      if (!pre_en_i) begin
        if (we_i) active_q <= wdata_i;
      end else if (upd_i) begin
        // same-cycle write wins over stale shadow
        active_q <= we_i ? wdata_i : shadow_q;
      end
    end
  end

  assign active_o = active_q;

  assert_direct_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_en_i && we_i) |=> (active_o == $past(wdata_i)));
  assert_preload_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_en_i && !upd_i) |=> $stable(active_o));
  assert_upd_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_en_i && upd_i && we_i) |=> (active_o == $past(wdata_i)));
endmodule

// File: rtl/oc_ref_logic.sv
module oc_ref_logic
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             ocref_o,
  output logic             match_o
);
  logic ref_q, ref_d, match_q, eq, pwm_lvl;

  assign eq      = (cnt_i == cmp_i);
  assign pwm_lvl = cnt_down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);

  always_comb begin
    case (mode_i)
      OC_HOLD:     ref_d = ref_q;
      OC_SET_EQ:   ref_d = eq ? 1'b1 : ref_q;
      OC_CLR_EQ:   ref_d = eq ? 1'b0 : ref_q;
      OC_TOG_EQ:   ref_d = eq ? ~ref_q : ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_A:    ref_d = pwm_lvl;
      OC_PWM_B:    ref_d = ~pwm_lvl;
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      match_q <= eq;
    end
  end

  assign ocref_o = ref_q;
  assign match_o = match_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_HOLD) |=> $stable(ocref_o));
  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_TOG_EQ && cnt_i == cmp_i) |=> (ocref_o != $past(ocref_o)));
  assert_force_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FORCE_LO) |=> !ocref_o);
  assert_force_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FORCE_HI) |=> ocref_o);
  assert_set_eq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_SET_EQ && cnt_i == cmp_i) |=> ocref_o);
  assert_match_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != cmp_i) |=> !match_o);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] cmp_active_o,
  output logic             ocref_o,
  output logic             match_o
);
  oc_ctrl_t ctrl_q;
  logic [CNT_W-1:0] cmp_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= oc_ctrl_t'(ctrl_wdata_i);
  end

  oc_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pre_en_i (ctrl_q.pre_en),
    .upd_i    (upd_i),
    .we_i     (cmp_we_i),
    .wdata_i  (cmp_wdata_i),
    .active_o (cmp_act)
  );

  oc_ref_logic #(.CNT_W(CNT_W)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (ctrl_q.mode),
    .cnt_i      (cnt_i),
    .cnt_down_i (cnt_down_i),
    .cmp_i      (cmp_act),
    .ocref_o    (ocref_o),
    .match_o    (match_o)
  );

  assign ctrl_o       = ctrl_q;
  assign cmp_active_o = cmp_act;

  assert_ctrl_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == $past(ctrl_wdata_i)));
  assert_ctrl_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
endmodule

// File: tb/sim_oc_channel.sv
`timescale 1ns/1ps
module sim_oc_channel;
  localparam int W = 16;
  localparam logic [W-1:0] CMPV = 16'd100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt = '0, cmp_wd = '0;
  logic down = 1'b0, upd = 1'b0, ctrl_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] ctrl_wd = '0;
  logic [7:0] ctrl;
  logic [W-1:0] cmp_act;
  logic ocref, match;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  oc_channel #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(down), .upd_i(upd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .cmp_we_i(cmp_we),
    .cmp_wdata_i(cmp_wd), .ctrl_o(ctrl), .cmp_active_o(cmp_act),
    .ocref_o(ocref), .match_o(match)
  );

  // vector: {mode[2:0], down, cnt[15:0], expected ocref}, compare fixed at 100
  localparam logic [20:0] VEC [12] = '{
    {3'd6, 1'b0, 16'd50,  1'b1}, {3'd6, 1'b0, 16'd100, 1'b0},
    {3'd6, 1'b0, 16'd150, 1'b0}, {3'd6, 1'b1, 16'd150, 1'b0},
    {3'd6, 1'b1, 16'd100, 1'b1}, {3'd6, 1'b1, 16'd50,  1'b1},
    {3'd7, 1'b0, 16'd50,  1'b0}, {3'd7, 1'b0, 16'd100, 1'b1},
    {3'd7, 1'b1, 16'd150, 1'b1}, {3'd7, 1'b1, 16'd100, 1'b0},
    {3'd4, 1'b1, 16'd100, 1'b0}, {3'd5, 1'b0, 16'd7,   1'b1}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wd = v;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic wcmp(input logic [W-1:0] v, input logic with_upd);
    cmp_we = 1'b1; cmp_wd = v; upd = with_upd;
    step();
    cmp_we = 1'b0; upd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cnt = 16'd1;
    step(); step();
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl), 32'h0);
    chk("R1 cmp", 32'(cmp_act), 32'h0);
    chk("R1 ocref", 32'(ocref), 32'h0);
    chk("R1 match", 32'(match), 32'h0);
    rst_n = 1'b1;
    step();

    // R9 direct load with preload clear
    wcmp(CMPV, 1'b0);
    chk("R9 direct", 32'(cmp_act), 32'(CMPV));

    // R7/R8/R6 table walk
    for (int i = 0; i < 12; i++) begin
      wctrl({1'b0, VEC[i][20:18], 4'b0000});
      down = VEC[i][17]; cnt = VEC[i][16:1];
      step();
      chk("R6/R7/R8 vector", 32'(ocref), 32'(VEC[i][0]));
    end

    // R13 mode change takes effect the cycle after the write
    wctrl(8'h40); cnt = 16'd1; step();
    chk("R13 settle", 32'(ocref), 32'h0);
    ctrl_we = 1'b1; ctrl_wd = 8'h50;
    step();
    ctrl_we = 1'b0;
    chk("R13 old mode", 32'(ocref), 32'h0);
    step();
    chk("R13 new mode", 32'(ocref), 32'h1);

    // R2 extra bits stored and inert: clr=1, mode 5, fast=1, sel=11
    wctrl(8'hD7);
    chk("R2 readback", 32'(ctrl), 32'hD7);
    wctrl(8'h40); step();
    wctrl(8'hD7); step();
    chk("R2 extras inert", 32'(ocref), 32'h1);

    // R3 hold from high while matching
    wctrl(8'h00); cnt = CMPV; step(); step();
    chk("R3 hold high", 32'(ocref), 32'h1);
    cnt = 16'd3; wctrl(8'h40); step();
    wctrl(8'h00); cnt = CMPV; step();
    chk("R3 hold low", 32'(ocref), 32'h0);

    // R4 set / clear on match
    cnt = 16'd3; wctrl(8'h10); step();
    chk("R4 set no match", 32'(ocref), 32'h0);
    cnt = CMPV; step();
    chk("R4 set match", 32'(ocref), 32'h1);
    cnt = 16'd5; step();
    chk("R4 set holds", 32'(ocref), 32'h1);
    wctrl(8'h20); step();
    chk("R4 clr no match", 32'(ocref), 32'h1);
    cnt = CMPV; step();
    chk("R4 clr match", 32'(ocref), 32'h0);

    // R5 toggle per matching cycle
    cnt = 16'd5; wctrl(8'h30); step();
    chk("R5 idle", 32'(ocref), 32'h0);
    cnt = CMPV; step();
    chk("R5 first toggle", 32'(ocref), 32'h1);
    step();
    chk("R5 second toggle", 32'(ocref), 32'h0);
    cnt = 16'd6; step();
    chk("R5 hold", 32'(ocref), 32'h0);

    // R12 match pulse in forced mode
    wctrl(8'h40);
    cnt = CMPV; step();
    chk("R12 pulse", 32'(match), 32'h1);
    cnt = 16'd99; step();
    chk("R12 pulse ends", 32'(match), 32'h0);

    // R10 preload
    wctrl(8'h08);
    wcmp(16'd300, 1'b0);
    chk("R10 before update", 32'(cmp_act), 32'(CMPV));
    step();
    chk("R10 still held", 32'(cmp_act), 32'(CMPV));
    upd = 1'b1; step(); upd = 1'b0;
    chk("R10 after update", 32'(cmp_act), 32'd300);

    // R11 same-cycle write and update
    wcmp(16'd400, 1'b1);
    chk("R11 new value wins", 32'(cmp_act), 32'd400);

    // R12 match tracks new active value
    cnt = 16'd400; step();
    chk("R12 new compare", 32'(match), 32'h1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule